// File: doc/BRIEF.md
# Dual-Select Synthesizer Register Writer

This block is a transmit-only serial master that programs the tuning registers of two synthesizer devices. The devices share one serial clock and one data line; each device has its own active-low chip select. A requester hands over one register write at a time on a valid/ready handshake. The request names the target device, the register kind and a data word. The block then shifts out an instruction byte followed by the register payload, most significant bit first.

Two register kinds exist. A frequency write carries a 32-bit tuning word as four data bytes. A phase write carries a phase given in milliturns. The block converts that phase to a 14-bit word and sends it as two data bytes. After each transfer the chip select stays high for a fixed recovery gap before the next request is accepted. The serial bit period is set by a clock divider parameter. With the default value and a 125 MHz system clock, the bit rate is about 1 Mbit/s.

Top module: `synth_reg_writer`

## Requirements
- R1: After synchronous reset, `spi_cs_n` is all ones, `spi_sclk` is 0, `spi_mosi` is 0 and `req_ready` is 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the recovery gap has ended. While `req_ready` is 0, `req_valid` and the request fields have no effect on the pins.
- R3: Every transfer begins with an 8-bit instruction byte. Bit 7 is 0 (write), bits 6:5 are 0, and bits 4:0 hold the register address: 0x04 for frequency (`req_kind`=0) and 0x05 for phase (`req_kind`=1).
- R4: A frequency transfer is 40 bits long: the instruction byte, then `req_data[31:0]`, most significant bit first.
- R5: A phase transfer is 24 bits long: the instruction byte, then two zero bits, then the 14-bit phase word, most significant bit first.
- R6: The phase word is floor((mt*16384 + 500)/1000) modulo 16384, where mt = `req_data[9:0]`. `req_data[31:10]` does not affect a phase transfer.
- R7: `req_dev`=0 drives `spi_cs_n[0]` low and `req_dev`=1 drives `spi_cs_n[1]` low. At most one select is low at any time, and the chosen select stays low from the first instruction bit to the end of the last data bit.
- R8: Timing is counted from the cycle after acceptance. For each bit, `spi_sclk` is 0 for CLK_DIV cycles and then 1 for CLK_DIV cycles. `spi_mosi` presents the bit for that whole window, so it changes only at points where the clock falls. `spi_sclk` idles at 0.
- R9: After the last bit, `spi_cs_n` is all ones and `spi_sclk` and `spi_mosi` are 0 for 2*CLK_DIV cycles. `req_ready` returns to 1 in the cycle after that.
- R10: A reset raised during a transfer returns all pins to the R1 state in the cycle after the reset edge. The next request after reset then produces a complete transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_dev | input | DEV_W (1) | Target device index |
| req_kind | input | 1 | 0 = frequency word, 1 = phase in milliturns |
| req_data | input | 32 | Frequency word, or milliturns in bits 9:0 |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to both devices |
| spi_cs_n | output | NUM_DEV (2) | Per-device chip select, active low |

## Verification
A corrupted shift register or bit counter shows up on the data line within one bit time. It also changes the number of rising clock edges seen inside a select window, and that count is checked when the select rises. A wrong state or timer value moves a clock edge or a select edge by at least one system cycle. The bench models the pins cycle by cycle, so such a shift is flagged on the first cycle where it occurs. A wrong device latch lowers the other select on the first cycle after acceptance. A conversion error appears in the decoded phase payload at the end of that same transfer.

// File: rtl/synth_wr_pkg.sv
package synth_wr_pkg;

    localparam int INSTR_BITS  = 8;
    localparam int WORD_BITS   = 32;
    localparam int PHASE_BITS  = 14;
    localparam int PHASE_PAD   = 2;
    localparam int MT_BITS     = 10;
    localparam int FRAME_MAX   = INSTR_BITS + WORD_BITS;
    localparam int FRAME_PHASE = INSTR_BITS + PHASE_PAD + PHASE_BITS;
    localparam int LEN_W       = $clog2(FRAME_MAX + 1);

    localparam logic [4:0] ADDR_FREQ  = 5'h04;
    localparam logic [4:0] ADDR_PHASE = 5'h05;

    typedef enum logic {
        KIND_FREQ  = 1'b0,
        KIND_PHASE = 1'b1
    } reg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } eng_state_e;

    // Left-aligned serial image plus the number of bits to send
    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [LEN_W-1:0]     len;
    } frame_t;

    // Write instruction: direction bit low, two reserved zeros, address
    function automatic logic [INSTR_BITS-1:0] make_instr(input logic [4:0] addr);
        return {1'b0, 2'b00, addr};
    endfunction

    // Milliturns to 14-bit phase word with round-half-up, wrapping at one turn
    function automatic logic [PHASE_BITS-1:0] mt_to_phase(input logic [MT_BITS-1:0] mt);
        logic [24:0] scaled;
        scaled = {1'b0, mt, 14'd0} + 25'd500;
        return PHASE_BITS'(scaled / 25'd1000);
    endfunction

endpackage

// File: rtl/synth_frame_pack.sv
module synth_frame_pack
    import synth_wr_pkg::*;
(
    input  logic                 kind,
    input  logic [WORD_BITS-1:0] data,
    output frame_t               frame
);

    logic [PHASE_BITS-1:0] phase_word;

    assign phase_word = mt_to_phase(data[MT_BITS-1:0]);

    always_comb begin
        if (reg_kind_e'(kind) == KIND_FREQ) begin
            frame.bits = {make_instr(ADDR_FREQ), data};
            frame.len  = LEN_W'(FRAME_MAX);
        end else begin
            frame.bits = {make_instr(ADDR_PHASE), {PHASE_PAD{1'b0}}, phase_word,
                          {(FRAME_MAX - FRAME_PHASE){1'b0}}};
            frame.len  = LEN_W'(FRAME_PHASE);
        end
    end

endmodule

// File: rtl/synth_bit_timer.sv
module synth_bit_timer #(
    parameter int CLK_DIV = 62
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic long_win,
    output logic done
);

    localparam int CNT_W     = $clog2(2 * CLK_DIV) + 1;
    localparam int SHORT_END = CLK_DIV - 1;
    localparam int LONG_END  = 2 * CLK_DIV - 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == (long_win ? CNT_W'(LONG_END) : CNT_W'(SHORT_END)));

endmodule

// File: rtl/synth_shift_engine.sv
module synth_shift_engine
    import synth_wr_pkg::*;
#(
    parameter int DEV_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  frame_t           frame,
    input  logic [DEV_W-1:0] dev,
    input  logic             tick,
    output logic             ready,
    output logic             sclk,
    output logic             mosi,
    output logic             active,
    output logic [DEV_W-1:0] cur_dev,
    output logic             timer_clear,
    output logic             timer_long
);

    eng_state_e           state;
    logic [FRAME_MAX-1:0] shreg;
    logic [LEN_W-1:0]     bits_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            bits_left <= '0;
            cur_dev   <= '0;
            sclk      <= 1'b0;
            mosi      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        shreg     <= frame.bits;
                        bits_left <= frame.len;
                        cur_dev   <= dev;
                        mosi      <= frame.bits[FRAME_MAX-1];
                        sclk      <= 1'b0;
                        state     <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        sclk  <= 1'b1;
                        state <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sclk <= 1'b0;
                        if (bits_left == LEN_W'(1)) begin
                            mosi      <= 1'b0;
                            bits_left <= '0;
                            state     <= ST_GAP;
                        end else begin
                            shreg     <= {shreg[FRAME_MAX-2:0], 1'b0};
                            mosi      <= shreg[FRAME_MAX-2];
                            bits_left <= bits_left - 1'b1;
                            state     <= ST_LOW;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ready       = (state == ST_IDLE);
    assign active      = (state == ST_LOW) || (state == ST_HIGH);
    assign timer_clear = (state == ST_IDLE) || tick;
    assign timer_long  = (state == ST_GAP);

endmodule

// File: rtl/synth_reg_writer.sv
module synth_reg_writer
    import synth_wr_pkg::*;
#(
    parameter int CLK_DIV = 62,
    parameter int NUM_DEV = 2,
    parameter int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [DEV_W-1:0]     req_dev,
    input  logic                 req_kind,
    input  logic [WORD_BITS-1:0] req_data,
    output logic                 spi_sclk,
    output logic                 spi_mosi,
    output logic [NUM_DEV-1:0]   spi_cs_n
);

    frame_t           frame;
    logic             start;
    logic             tick;
    logic             active;
    logic [DEV_W-1:0] cur_dev;
    logic             timer_clear;
    logic             timer_long;

    assign start = req_valid && req_ready;

    synth_frame_pack u_pack (
        .kind  (req_kind),
        .data  (req_data),
        .frame (frame)
    );

    synth_bit_timer #(.CLK_DIV(CLK_DIV)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clear    (timer_clear),
        .long_win (timer_long),
        .done     (tick)
    );

    synth_shift_engine #(.DEV_W(DEV_W)) u_engine (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .frame       (frame),
        .dev         (req_dev),
        .tick        (tick),
        .ready       (req_ready),
        .sclk        (spi_sclk),
        .mosi        (spi_mosi),
        .active      (active),
        .cur_dev     (cur_dev),
        .timer_clear (timer_clear),
        .timer_long  (timer_long)
    );

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_cs
        assign spi_cs_n[g] = ~(active && (cur_dev == DEV_W'(g)));
    end

endmodule

// File: rtl/synth_reg_writer_chk.sv
module synth_reg_writer_chk #(
    parameter int NUM_DEV = 2,
    parameter int DEV_W   = 1
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic [DEV_W-1:0]   req_dev,
    input logic               spi_sclk,
    input logic               spi_mosi,
    input logic [NUM_DEV-1:0] spi_cs_n
);

    localparam logic [NUM_DEV-1:0] ALL_HIGH = '1;

    // R7: never two devices selected
    p_single_select_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~spi_cs_n));

    // R7: accepted device is the one selected
    p_select_matches_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (spi_cs_n == ~(NUM_DEV'(1) << $past(req_dev))));

    // R7: select does not switch mid-transfer
    p_select_held_r7: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n != ALL_HIGH && $past(spi_cs_n) != ALL_HIGH) |-> (spi_cs_n == $past(spi_cs_n)));

    // R8: clock pulses only inside a select window
    p_clock_in_window_r8: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> (spi_cs_n != ALL_HIGH));

    // R8: data held while the clock is high
    p_data_steady_high_r8: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R2: acceptance starts a transfer and drops ready
    p_accept_starts_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!req_ready && spi_cs_n != ALL_HIGH));

    // R9: ready only when the lines are quiet
    p_ready_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (spi_cs_n == ALL_HIGH && !spi_sclk));

endmodule

bind synth_reg_writer synth_reg_writer_chk #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_dev   (req_dev),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_cs_n  (spi_cs_n)
);

// File: tb/synth_reg_writer_tb.sv
`timescale 1ns/1ps
module synth_reg_writer_tb;

    localparam int D = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [0:0]  req_dev = 1'b0;
    logic        req_kind = 1'b0;
    logic [31:0] req_data = '0;
    logic        spi_sclk;
    logic        spi_mosi;
    logic [1:0]  spi_cs_n;

    int tests = 0;
    int fails = 0;
    int prints = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    synth_reg_writer #(.CLK_DIV(D), .NUM_DEV(2)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_dev(req_dev), .req_kind(req_kind), .req_data(req_data),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
    );

    // expected pin image per cycle: {cs_n[1:0], sclk, mosi, ready}
    logic [4:0]  exp_q[$];
    logic [63:0] fr_val_q[$];
    int          fr_len_q[$];
    int          fr_dev_q[$];

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            if (prints < 20) begin
                $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
                prints++;
            end
        end
    endtask

    function automatic int phase_of(input logic [31:0] d);
        longint mt;
        mt = longint'(d[9:0]);
        return int'(((mt * 16384 + 500) / 1000) % 16384);
    endfunction

    // reference: on acceptance, build frame and per-cycle pin image
    always @(posedge clk) begin
        if (rst) begin
            exp_q.delete();
            fr_val_q.delete();
            fr_len_q.delete();
            fr_dev_q.delete();
        end else if (req_valid && req_ready) begin
            logic [63:0] val;
            int len;
            logic [1:0] csv;
            if (req_kind == 1'b0) begin
                val = {24'd0, 8'h04, req_data};
                len = 40;
            end else begin
                val = {40'd0, 8'h05, 2'b00, 14'(phase_of(req_data))};
                len = 24;
            end
            csv = (req_dev == 1'b0) ? 2'b10 : 2'b01;
            fr_val_q.push_back(val);
            fr_len_q.push_back(len);
            fr_dev_q.push_back(int'(req_dev));
            for (int i = 0; i < len; i++) begin
                for (int c = 0; c < D; c++) exp_q.push_back({csv, 1'b0, val[len-1-i], 1'b0});
                for (int c = 0; c < D; c++) exp_q.push_back({csv, 1'b1, val[len-1-i], 1'b0});
            end
            for (int c = 0; c < 2 * D; c++) exp_q.push_back(5'b11_0_0_0);
        end
    end

    // R4/R5/R7/R8/R9 cycle-by-cycle comparison of the pins
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            logic [4:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 5'b11_0_0_1;
            chk("R8 R9 pin image", {59'd0, spi_cs_n, spi_sclk, spi_mosi, req_ready}, {59'd0, e});
        end
    end

    // slave decoder: counts rising clocks inside a select window
    logic [63:0] sl_sh = '0;
    int          sl_cnt = 0;
    int          sl_dev = 0;
    logic        prev_sclk = 1'b0;
    logic [1:0]  prev_cs = 2'b11;

    always @(negedge clk) begin
        if (rst) begin
            sl_sh = '0; sl_cnt = 0; prev_sclk = 1'b0; prev_cs = 2'b11;
        end else begin
            if (spi_sclk && !prev_sclk && spi_cs_n != 2'b11) begin
                sl_sh  = {sl_sh[62:0], spi_mosi};
                sl_cnt++;
                sl_dev = (spi_cs_n == 2'b10) ? 0 : 1;
            end
            if (spi_cs_n == 2'b11 && prev_cs != 2'b11) begin
                if (fr_len_q.size() == 0) begin
                    chk("R2 unexpected transfer", 64'd1, 64'd0);
                end else begin
                    logic [63:0] v;
                    int l;
                    int dv;
                    v  = fr_val_q.pop_front();
                    l  = fr_len_q.pop_front();
                    dv = fr_dev_q.pop_front();
                    chk("R4 R5 bit count", 64'(sl_cnt), 64'(l));
                    chk("R3 instruction byte", 64'(sl_sh[l-1 -: 8]), 64'(v[l-1 -: 8]));
                    chk("R4 R5 R6 payload", sl_sh & ((64'd1 << (l - 8)) - 1),
                        v & ((64'd1 << (l - 8)) - 1));
                    chk("R7 device", 64'(sl_dev), 64'(dv));
                end
                sl_sh = '0;
                sl_cnt = 0;
            end
            prev_sclk = spi_sclk;
            prev_cs   = spi_cs_n;
        end
    end

    task automatic send(input logic dev, input logic kind, input logic [31:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_dev = dev; req_kind = kind; req_data = d;
        @(negedge clk);
        req_valid = 1'b0; req_data = 32'hDEAD_BEEF;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (exp_q.size() > 0 || !req_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state (still in reset, after edges)
        chk("R1 cs_n", 64'(spi_cs_n), 64'd3);
        chk("R1 sclk", 64'(spi_sclk), 64'd0);
        chk("R1 mosi", 64'(spi_mosi), 64'd0);
        chk("R1 ready", 64'(req_ready), 64'd1);
        rst = 1'b0;

        // R4 frequency writes on both devices
        send(1'b0, 1'b0, 32'hA5C3_1E7F); wait_idle();
        send(1'b1, 1'b0, 32'h8000_0001); wait_idle();
        send(1'b0, 1'b0, 32'hFFFF_FFFF); wait_idle();

        // R5 R6 phase conversions: exact, rounding, near-wrap, wrap
        send(1'b1, 1'b1, 32'd250);  wait_idle();   // 4096
        send(1'b0, 1'b1, 32'd1);    wait_idle();   // 16
        send(1'b1, 1'b1, 32'd999);  wait_idle();   // 16368
        send(1'b0, 1'b1, 32'd0);    wait_idle();   // 0
        send(1'b1, 1'b1, 32'd1000); wait_idle();   // 16384 wraps to 0
        // R6 upper bits ignored: mt = 333 -> 5456
        send(1'b0, 1'b1, 32'hABCD_E000 | 32'd333); wait_idle();

        // R9 back-to-back: second waits through the gap
        send(1'b0, 1'b0, 32'h1234_5678);
        send(1'b1, 1'b1, 32'd500);
        wait_idle();

        // R2 valid while busy has no effect
        send(1'b0, 1'b0, 32'h0F0F_0F0F);
        repeat (10) @(negedge clk);
        req_valid = 1'b1; req_dev = 1'b1; req_kind = 1'b1; req_data = 32'd77;
        repeat (20) @(negedge clk);
        chk("R2 ready low while busy", 64'(req_ready), 64'd0);
        req_valid = 1'b0;
        wait_idle();

        // R10 reset in the middle of a transfer
        send(1'b1, 1'b0, 32'hCAFE_F00D);
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 cs_n after reset", 64'(spi_cs_n), 64'd3);
        chk("R10 sclk after reset", 64'(spi_sclk), 64'd0);
        chk("R10 ready after reset", 64'(req_ready), 64'd1);
        rst = 1'b0;
        send(1'b0, 1'b1, 32'd750); wait_idle();    // 12288

        finish_run();
    end

endmodule